// File: doc/BRIEF.md
# DMA Channel Flow Sequencer

This block is the control engine of a single DMA channel. Software loads a source address, a destination address, a next-descriptor pointer and a control word, then enables the channel. The channel then waits for peripheral requests and issues one data beat per cycle on the shared bus whenever the request is up, the channel wins the priority contest and the bus is granted. Two flows are handled. In peripheral-to-memory flow, source beats are the whole transfer. In peripheral-to-peripheral flow, source beats fill an internal FIFO and destination beats drain it. The FIFO is tracked only as an occupancy count.

A transfer ends in one of two ways. Under engine flow control it ends when a down-counter loaded from the control word runs out. Under peripheral flow control it ends when the peripheral flags its last request. On completion the peripheral concerned gets a one-cycle acknowledge and a maskable terminal-count flag is raised. The channel then either fetches the next descriptor, four words through a simple read port, and carries on, or it switches itself off. A bus error on any beat raises a sticky error flag and disables the channel at once.

Control word layout: bits [CNT_W-1:0] hold the transfer count, bit 16 selects peripheral-to-peripheral flow, bit 17 selects peripheral flow control, and bit 31 enables the terminal-count flag.

Top module: `dma_flow_seq`

## Requirements
- R1: After reset the channel is disabled. `ch_en`, `xfer_stb`, `src_ack`, `dst_ack`, `irq_tc`, `irq_err` and `mem_rd` are 0, and the descriptor registers read 0.
- R2: `cfg_we` loads the four descriptor registers only while the channel is disabled and is ignored while it is enabled. `en_set` enables a disabled channel, and `ch_en` reads 1 from the next cycle.
- R3: `xfer_stb` is high in a cycle only when the channel is enabled and not fetching, `prio_win` and `bus_gnt` are both high, and the request of the side being served is high.
- R4: Under engine flow control (bit 17 = 0) with count N, the Nth source beat completes the source side. `src_ack` pulses high for exactly one cycle, in the cycle after that beat.
- R5: Under peripheral flow control (bit 17 = 1) the count field is ignored. A source beat taken with `src_last` high completes the source side, and a destination beat taken with `dst_last` high completes the destination side.
- R6: On completion of the whole transfer, `irq_tc` is set in the next cycle if bit 31 of the active control word is 1, and stays unchanged otherwise. Once set it holds until a cycle with `clr_tc` high. A set in the same cycle wins over the clear.
- R7: On completion with a nonzero next pointer P, the channel reads four words with `mem_rd` held high, at P, P+4, P+8 and P+12 in turn. Each word is taken when `mem_rvalid` is high, and the words load source address, destination address, next pointer and control word, in that order. The channel then waits for requests again, with its counts reloaded from the new control word. A zero pointer disables the channel.
- R8: In peripheral-to-peripheral flow (bit 16 = 1), source beats (`xfer_wr` = 0) stop while the FIFO holds FIFO_DEPTH entries. A destination beat (`xfer_wr` = 1) needs `dst_req` and a nonempty FIFO. A destination beat wins over a source beat in the same cycle.
- R9: In peripheral-to-peripheral flow, source completion pulses `src_ack` and does not raise `irq_tc`. After it, source requests cause no further source beats until the next descriptor or re-enable.
- R10: In peripheral-to-peripheral flow, destination completion pulses `dst_ack` for one cycle and triggers the terminal-count and reload handling of R6 and R7. `src_ack` and `dst_ack` are never high together.
- R11: `xfer_err` high during a beat sets `irq_err` in the next cycle, disables the channel and produces no acknowledge. `irq_err` holds until `clr_err`.
- R12: Re-enabling a disabled channel restarts the request wait with an empty FIFO and counts reloaded from the full control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load descriptor registers (disabled only) |
| cfg_src | input | 32 | Source address to load |
| cfg_dst | input | 32 | Destination address to load |
| cfg_next | input | 32 | Next-descriptor pointer to load |
| cfg_ctrl | input | 32 | Control word to load |
| en_set | input | 1 | Enable the channel |
| src_req | input | 1 | Source peripheral request |
| src_last | input | 1 | Source marks its final request |
| dst_req | input | 1 | Destination peripheral request |
| dst_last | input | 1 | Destination marks its final request |
| prio_win | input | 1 | Channel holds the highest pending priority |
| bus_gnt | input | 1 | Engine owns the bus |
| xfer_err | input | 1 | Error on the current beat |
| xfer_stb | output | 1 | A data beat happens this cycle |
| xfer_wr | output | 1 | The beat is a destination write |
| src_ack | output | 1 | Source completion acknowledge pulse |
| dst_ack | output | 1 | Destination completion acknowledge pulse |
| mem_rd | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_rdata | input | 32 | Descriptor read data |
| mem_rvalid | input | 1 | Read data valid |
| irq_tc | output | 1 | Terminal-count flag |
| irq_err | output | 1 | Error flag |
| clr_tc | input | 1 | Clear terminal-count flag |
| clr_err | input | 1 | Clear error flag |
| ch_en | output | 1 | Channel enabled |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| next_ptr | output | 32 | Current next-descriptor pointer |
| ctrl_word | output | 32 | Current control word |

## Verification
The bench builds the block with CNT_W = 8 and FIFO_DEPTH = 2. The shallow FIFO fills after two source beats, so back-pressure on the source side and the priority of destination beats both come up in almost every peripheral-to-peripheral run. The narrow count keeps engine-controlled transfers to a handful of beats. That leaves room to run a two-link descriptor chain, with randomly stalled read data, inside one short test. Requests, priority and grant are randomized each cycle, so beats fall at irregular positions relative to completion and FIFO state.

// File: rtl/dma_flow_seq.sv
module dma_flow_seq #(
  parameter int CNT_W      = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_src,
  input  logic [31:0] cfg_dst,
  input  logic [31:0] cfg_next,
  input  logic [31:0] cfg_ctrl,
  input  logic        en_set,
  input  logic        src_req,
  input  logic        src_last,
  input  logic        dst_req,
  input  logic        dst_last,
  input  logic        prio_win,
  input  logic        bus_gnt,
  input  logic        xfer_err,
  output logic        xfer_stb,
  output logic        xfer_wr,
  output logic        src_ack,
  output logic        dst_ack,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rvalid,
  output logic        irq_tc,
  output logic        irq_err,
  input  logic        clr_tc,
  input  logic        clr_err,
  output logic        ch_en,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr,
  output logic [31:0] next_ptr,
  output logic [31:0] ctrl_word
);
  localparam int FW     = $clog2(FIFO_DEPTH + 1);
  localparam int P2P_B  = 16;
  localparam int PFL_B  = 17;
  localparam int TCIE_B = 31;

  typedef enum logic [1:0] {S_OFF, S_RUN, S_FETCH} st_t;

  st_t              st;
  logic [31:0]      src_r, dst_r, nxt_r, ctl_r, fbase;
  logic [CNT_W-1:0] s_left, d_left;
  logic [FW-1:0]    fill;
  logic [1:0]       fidx;
  logic             s_done;

  logic        p2p, pfl, go, src_beat, dst_beat, err, src_end, dst_end, fin;
  logic [31:0] ctl_n;

  assign p2p      = ctl_r[P2P_B];
  assign pfl      = ctl_r[PFL_B];
  assign go       = (st == S_RUN) && prio_win && bus_gnt;
  assign dst_beat = go && p2p && dst_req && (fill != '0);
  assign src_beat = go && !dst_beat && src_req && !s_done &&
                    (!p2p || fill != FW'(FIFO_DEPTH));
  assign xfer_stb = src_beat || dst_beat;
  assign xfer_wr  = dst_beat;
  assign err      = xfer_stb && xfer_err;
  assign src_end  = src_beat && !xfer_err && (pfl ? src_last : (s_left == CNT_W'(1)));
  assign dst_end  = dst_beat && !xfer_err && (pfl ? dst_last : (d_left == CNT_W'(1)));
  assign fin      = p2p ? dst_end : src_end;
  assign ctl_n    = cfg_we ? cfg_ctrl : ctl_r;

  assign mem_rd    = (st == S_FETCH);
  assign mem_addr  = fbase + {28'd0, fidx, 2'b00};
  assign ch_en     = (st != S_OFF);
  assign src_addr  = src_r;
  assign dst_addr  = dst_r;
  assign next_ptr  = nxt_r;
  assign ctrl_word = ctl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      src_r   <= '0;
      dst_r   <= '0;
      nxt_r   <= '0;
      ctl_r   <= '0;
      fbase   <= '0;
      s_left  <= '0;
      d_left  <= '0;
      fill    <= '0;
      fidx    <= '0;
      s_done  <= 1'b0;
      src_ack <= 1'b0;
      dst_ack <= 1'b0;
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      src_ack <= src_end;
      dst_ack <= dst_end;
      irq_tc  <= (fin && ctl_r[TCIE_B]) || (irq_tc && !clr_tc);
      irq_err <= err || (irq_err && !clr_err);
      case (st)
        S_OFF: begin
          if (cfg_we) begin
            src_r <= cfg_src;
            dst_r <= cfg_dst;
            nxt_r <= cfg_next;
            ctl_r <= cfg_ctrl;
          end
          if (en_set) begin
            st     <= S_RUN;
            s_left <= ctl_n[CNT_W-1:0];
            d_left <= ctl_n[CNT_W-1:0];
            s_done <= 1'b0;
            fill   <= '0;
          end
        end
        S_RUN: begin
          fill <= fill + FW'(src_beat && p2p) - FW'(dst_beat);
          if (src_beat) s_left <= s_left - CNT_W'(1);
          if (dst_beat) d_left <= d_left - CNT_W'(1);
          if (src_end && p2p) s_done <= 1'b1;
          if (err) begin
            st <= S_OFF;
          end else if (fin) begin
            if (nxt_r != '0) begin
              st    <= S_FETCH;
              fbase <= nxt_r;
              fidx  <= '0;
            end else begin
              st <= S_OFF;
            end
          end
        end
        S_FETCH: begin
          if (mem_rvalid) begin
            fidx <= fidx + 2'd1;
            case (fidx)
              2'd0: src_r <= mem_rdata;
              2'd1: dst_r <= mem_rdata;
              2'd2: nxt_r <= mem_rdata;
              default: begin
                ctl_r  <= mem_rdata;
                st     <= S_RUN;
                s_left <= mem_rdata[CNT_W-1:0];
                d_left <= mem_rdata[CNT_W-1:0];
                s_done <= 1'b0;
                fill   <= '0;
              end
            endcase
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/dma_flow_seq_chk.sv
module dma_flow_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_stb,
  input logic xfer_wr,
  input logic xfer_err,
  input logic prio_win,
  input logic bus_gnt,
  input logic src_req,
  input logic dst_req,
  input logic ch_en,
  input logic src_ack,
  input logic dst_ack,
  input logic irq_tc,
  input logic clr_tc,
  input logic irq_err,
  input logic mem_rd
);
  // R3
  stb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (prio_win && bus_gnt && ch_en && (xfer_wr ? dst_req : src_req)));

  // R4
  sack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |=> !src_ack);

  // R10
  dack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_ack |=> !dst_ack);

  // R10
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_ack, dst_ack}));

  // R6
  tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tc && !clr_tc) |=> irq_tc);

  // R11
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && xfer_err) |=> (!ch_en && irq_err && !src_ack && !dst_ack));

  // R7
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (ch_en && !xfer_stb));
endmodule

bind dma_flow_seq dma_flow_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb), .xfer_wr(xfer_wr),
  .xfer_err(xfer_err), .prio_win(prio_win), .bus_gnt(bus_gnt),
  .src_req(src_req), .dst_req(dst_req), .ch_en(ch_en), .src_ack(src_ack),
  .dst_ack(dst_ack), .irq_tc(irq_tc), .clr_tc(clr_tc), .irq_err(irq_err),
  .mem_rd(mem_rd)
);

// File: tb/tb_dma_flow_seq.sv
module tb_dma_flow_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, en_set = 0, src_req = 0, src_last = 0, dst_req = 0, dst_last = 0;
  logic prio_win = 0, bus_gnt = 0, xfer_err = 0, mem_rvalid = 0, clr_tc = 0, clr_err = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0, cfg_next = 0, cfg_ctrl = 0;
  logic xfer_stb, xfer_wr, src_ack, dst_ack, mem_rd, irq_tc, irq_err, ch_en;
  logic [31:0] mem_addr, mem_rdata, src_addr, dst_addr, next_ptr, ctrl_word;
  logic [31:0] mem [0:31];

  int total = 0, bad = 0;
  int n_sb = 0, n_db = 0, n_sa = 0, n_da = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[6:2]];

  dma_flow_seq #(.CNT_W(8), .FIFO_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_next(cfg_next), .cfg_ctrl(cfg_ctrl), .en_set(en_set), .src_req(src_req),
    .src_last(src_last), .dst_req(dst_req), .dst_last(dst_last), .prio_win(prio_win),
    .bus_gnt(bus_gnt), .xfer_err(xfer_err), .xfer_stb(xfer_stb), .xfer_wr(xfer_wr),
    .src_ack(src_ack), .dst_ack(dst_ack), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .irq_tc(irq_tc), .irq_err(irq_err),
    .clr_tc(clr_tc), .clr_err(clr_err), .ch_en(ch_en), .src_addr(src_addr),
    .dst_addr(dst_addr), .next_ptr(next_ptr), .ctrl_word(ctrl_word)
  );

  // behavioural reference model
  bit m_on, m_fetch, m_sdone, m_sack, m_dack, m_tc, m_err, e_s, e_d;
  logic [31:0] m_src, m_dst, m_nxt, m_ctl, m_fb, m_a;
  int m_sl, m_dl, m_fi;
  int q[$];
  bit nsa, nda, ends;

  task automatic m_eval();
    bit run, p2p;
    run = m_on && !m_fetch;
    p2p = m_ctl[16];
    e_d = run && prio_win && bus_gnt && p2p && dst_req && (q.size() > 0);
    e_s = run && prio_win && bus_gnt && !e_d && src_req && !m_sdone && (!p2p || q.size() < 2);
  endtask

  task automatic m_start();
    m_sl = int'(m_ctl[7:0]);
    m_dl = m_sl;
    m_sdone = 0;
    q.delete();
  endtask

  task automatic m_fin();
    if (m_ctl[31]) m_tc = 1;
    if (m_nxt != 0) begin
      m_fetch = 1; m_fb = m_nxt; m_fi = 0;
    end else m_on = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_fetch = 0; m_sdone = 0; m_sack = 0; m_dack = 0; m_tc = 0; m_err = 0;
      m_src = 0; m_dst = 0; m_nxt = 0; m_ctl = 0; m_fb = 0; m_sl = 0; m_dl = 0; m_fi = 0;
      q.delete();
    end else begin
      m_eval();
      nsa = 0; nda = 0;
      if (clr_tc) m_tc = 0;
      if (clr_err) m_err = 0;
      if (!m_on) begin
        if (cfg_we) begin
          m_src = cfg_src; m_dst = cfg_dst; m_nxt = cfg_next; m_ctl = cfg_ctrl;
        end
        if (en_set) begin
          m_on = 1; m_fetch = 0; m_start();
        end
      end else if (m_fetch) begin
        if (mem_rvalid) begin
          m_a = m_fb + 32'(4 * m_fi);
          case (m_fi)
            0: m_src = mem[m_a[6:2]];
            1: m_dst = mem[m_a[6:2]];
            2: m_nxt = mem[m_a[6:2]];
            default: m_ctl = mem[m_a[6:2]];
          endcase
          m_fi++;
          if (m_fi == 4) begin
            m_fetch = 0; m_start();
          end
        end
      end else if ((e_s || e_d) && xfer_err) begin
        m_err = 1; m_on = 0;
      end else begin
        if (e_s) begin
          if (m_ctl[16]) q.push_back(1);
          ends = m_ctl[17] ? src_last : (m_sl == 1);
          m_sl--;
          if (ends) begin
            nsa = 1;
            if (m_ctl[16]) m_sdone = 1; else m_fin();
          end
        end
        if (e_d) begin
          void'(q.pop_front());
          ends = m_ctl[17] ? dst_last : (m_dl == 1);
          m_dl--;
          if (ends) begin
            nda = 1; m_fin();
          end
        end
      end
      m_sack = nsa; m_dack = nda;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    m_eval();
    chk("R2 ch_en", ch_en, m_on);
    chk("R3 xfer_stb", xfer_stb, e_s || e_d);
    chk("R8 xfer_wr", xfer_wr, e_d);
    chk("R4 src_ack", src_ack, m_sack);
    chk("R10 dst_ack", dst_ack, m_dack);
    chk("R6 irq_tc", irq_tc, m_tc);
    chk("R11 irq_err", irq_err, m_err);
    chk("R7 mem_rd", mem_rd, m_on && m_fetch);
    if (m_on && m_fetch) chk("R7 mem_addr", mem_addr, m_fb + 32'(4 * m_fi));
    chk("R7 src_addr", src_addr, m_src);
    chk("R7 dst_addr", dst_addr, m_dst);
    chk("R7 next_ptr", next_ptr, m_nxt);
    chk("R7 ctrl_word", ctrl_word, m_ctl);
    if (xfer_stb && !xfer_wr) n_sb++;
    if (xfer_stb && xfer_wr) n_db++;
    if (src_ack) n_sa++;
    if (dst_ack) n_da++;
  endtask

  task automatic step();
    #1;
    compare();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rnd(input int n, input bit use_s, input bit use_d);
    for (int i = 0; i < n; i++) begin
      prio_win   = ($urandom % 4) != 0;
      bus_gnt    = ($urandom % 4) != 0;
      src_req    = use_s && (($urandom % 3) != 0);
      dst_req    = use_d && (($urandom % 3) != 0);
      mem_rvalid = ($urandom % 3) != 0;
      step();
    end
    src_req = 0; dst_req = 0;
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input logic [31:0] nx,
                      input logic [31:0] c);
    cfg_src = s; cfg_dst = d; cfg_next = nx; cfg_ctrl = c; cfg_we = 1;
    step();
    cfg_we = 0; en_set = 1;
    step();
    en_set = 0;
  endtask

  task automatic zero_cnt();
    n_sb = 0; n_db = 0; n_sa = 0; n_da = 0;
  endtask

  task automatic pulse_clr_tc();
    clr_tc = 1; step(); clr_tc = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    mem[16] = 32'h1000; mem[17] = 32'h2000; mem[18] = 32'h50; mem[19] = 32'h2;
    mem[20] = 32'h3000; mem[21] = 32'h4000; mem[22] = 32'h0; mem[23] = 32'h8000_0002;

    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 ch_en", ch_en, 0);
    chk("R1 irq_tc", irq_tc, 0);
    chk("R1 irq_err", irq_err, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 acks", {src_ack, dst_ack}, 0);
    chk("R1 src_addr", src_addr, 0);
    chk("R1 xfer_stb", xfer_stb, 0);
    @(negedge clk);

    // R4 R6 R2: engine flow, count 3, tc enabled, no chain
    zero_cnt();
    prog(32'h100, 32'h200, 32'h0, 32'h8000_0003);
    rnd(4, 1, 0);
    cfg_src = 32'hDEAD; cfg_we = 1; step(); cfg_we = 0;
    chk("R2 write ignored", src_addr, 32'h100);
    rnd(40, 1, 0);
    chk("R4 beats", n_sb, 3);
    chk("R4 acks", n_sa, 1);
    chk("R7 zero ptr off", ch_en, 0);
    chk("R6 tc set", irq_tc, 1);
    pulse_clr_tc();
    chk("R6 tc cleared", irq_tc, 0);

    // R7 chain of two descriptors, first one masked
    zero_cnt();
    prog(32'h500, 32'h600, 32'h40, 32'h0000_0002);
    rnd(100, 1, 0);
    chk("R7 beats", n_sb, 6);
    chk("R7 acks", n_sa, 3);
    chk("R7 src", src_addr, 32'h3000);
    chk("R7 dst", dst_addr, 32'h4000);
    chk("R7 off", ch_en, 0);
    chk("R6 tc from last", irq_tc, 1);
    pulse_clr_tc();

    // R5 peripheral flow control
    zero_cnt();
    prog(32'h0, 32'h0, 32'h0, 32'h8002_0001);
    rnd(20, 1, 0);
    chk("R5 count ignored", ch_en, 1);
    chk("R5 no ack", n_sa, 0);
    src_last = 1;
    rnd(30, 1, 0);
    src_last = 0;
    chk("R5 last ends", n_sa, 1);
    chk("R5 off", ch_en, 0);
    pulse_clr_tc();

    // R8 R9 R10 peripheral-to-peripheral, engine flow, count 5
    zero_cnt();
    prog(32'h0, 32'h0, 32'h0, 32'h8001_0005);
    rnd(15, 1, 0);
    chk("R8 fifo full", n_sb, 2);
    chk("R9 no tc", irq_tc, 0);
    rnd(100, 1, 1);
    chk("R9 src beats", n_sb, 5);
    chk("R10 dst beats", n_db, 5);
    chk("R9 src ack", n_sa, 1);
    chk("R10 dst ack", n_da, 1);
    chk("R10 tc", irq_tc, 1);
    pulse_clr_tc();

    // R10 R5 peripheral-to-peripheral, peripheral flow
    zero_cnt();
    prog(32'h0, 32'h0, 32'h0, 32'h8003_0001);
    rnd(10, 1, 1);
    dst_last = 1;
    rnd(40, 1, 1);
    dst_last = 0;
    chk("R10 pfl dst ack", n_da, 1);
    chk("R10 pfl off", ch_en, 0);
    pulse_clr_tc();

    // R11 error on a beat
    zero_cnt();
    prog(32'h0, 32'h0, 32'h0, 32'h0000_000A);
    src_req = 1; prio_win = 1; bus_gnt = 1;
    step(); step();
    xfer_err = 1; step(); xfer_err = 0; src_req = 0;
    chk("R11 off", ch_en, 0);
    chk("R11 flag", irq_err, 1);
    chk("R11 no ack", n_sa, 0);
    step();
    chk("R11 sticky", irq_err, 1);
    clr_err = 1; step(); clr_err = 0;
    chk("R11 cleared", irq_err, 0);

    // R12 re-enable restarts full count
    zero_cnt();
    en_set = 1; step(); en_set = 0;
    rnd(80, 1, 0);
    chk("R12 full count", n_sb, 10);
    chk("R12 ack", n_sa, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule